// File: doc/BRIEF.md
# IR Receive Queue with Interrupt Status

This block sits between an infrared sampling front end and a host processor. Each run-length byte that the front end produces is pushed into a first-in first-out queue. The host drains the queue one byte per read through a small register window. Three sticky event flags record conditions the host must service: a push that found the queue full, the end of a received packet, and the queue filling past a programmable level. An interrupt line is asserted while any flag is set whose enable bit is also set.

The host sees three registers, chosen by a 2-bit select. The first is an enable register that holds the three enable bits and the available-level threshold. The second is a status register that holds the three flags and the live fill count; writing ones to it clears flags. The third is a data port that pops the oldest byte on each read. Reads are combinational on the select. A pop, like every other state change, takes effect at the next rising clock edge.

Top module: `ir_rxq`

## Requirements
- R1: After reset the fill count is 0, all three flags are 0, the enable register reads 0 and irq_o is 0.
- R2: With reg_sel_i = 2 (data) and reg_re_i high, rdata_o[7:0] holds the oldest stored byte and rdata_o[31:8] is 0. The byte is removed at the next edge, and bytes leave in the order they were pushed.
- R3: A push_valid_i while the queue holds DEPTH entries and no pop happens in the same cycle is dropped. The stored bytes and the count stay unchanged, and status bit 0 (overflow) is set. A push and a pop in the same cycle on a full queue are both accepted.
- R4: Status (reg_sel_i = 1) bits [8 +: CNT_W] report the fill count. CNT_W = log2(DEPTH)+1, so the field is masked to 2*DEPTH-1, and a full queue reads DEPTH.
- R5: Status bit 4 (available) is set one edge after the fill count exceeds the level held in enable register bits [8 +: CNT_W]. A count equal to the level does not set it.
- R6: A pkt_end_i pulse sets status bit 1 (packet end) at the next edge.
- R7: A status write clears each flag whose bit position (0, 1, 4) is 1 in wdata_i. Zero bits leave their flags alone. A flag that is set and cleared in the same cycle ends up set.
- R8: irq_o is high exactly when some flag is set together with its enable bit. The enable register (reg_sel_i = 0) holds the enable bits at positions 0, 1 and 4.
- R9: A data read on an empty queue returns 0 and leaves the count at 0.
- R10: Writes to the data port, and reads of the status or enable registers, leave the queue contents and count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| push_valid_i | input | 1 | Run-length byte strobe from the sampler |
| push_data_i | input | 8 | Run-length byte |
| pkt_end_i | input | 1 | End-of-packet pulse from the sampler |
| reg_sel_i | input | 2 | Register select: 0 enable, 1 status, 2 data, 3 unused |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (pops on data select) |
| wdata_i | input | 32 | Register write data |
| rdata_o | output | 32 | Register read data |
| irq_o | output | 1 | Interrupt request |

## Verification
Two pairs of functions can fall in the same cycle. The first is a host clear of a flag and a new event that sets that same flag. The second is a sampler push and a host pop on a full queue. The bench drives pkt_end_i and a status write with bit 1 set on the same edge, and requires the packet-end flag to read 1 afterwards. It also drives a push and a data read together while 16 bytes are stored. That cycle must return the oldest byte, keep the count at 16 and leave the overflow flag clear; the pushed byte must then come out last in order.

// File: rtl/ir_rxq_pkg.sv
package ir_rxq_pkg;
  typedef enum logic [1:0] {
    SEL_IEN  = 2'd0,
    SEL_STA  = 2'd1,
    SEL_DAT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int NFLAG    = 3;
  localparam int FLG_OVF  = 0;
  localparam int FLG_PEND = 1;
  localparam int FLG_AVL  = 2;
  localparam int FIELD_LO = 8;
  // bit position of each flag / enable, indexed by flag number
  localparam int FLAG_POS [NFLAG] = '{0, 1, 4};
endpackage

// File: rtl/ir_rxq_fifo.sv
module ir_rxq_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [DW-1:0]    data_i,
  input  logic             pop_req_i,
  output logic [DW-1:0]    rd_data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             pop_o,
  output logic             drop_o
);
  logic [DW-1:0]    mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             empty, push_ok;

  assign empty   = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign pop_o   = pop_req_i & ~empty;
  assign push_ok = push_i & (~full_o | pop_o);
  assign drop_o  = push_i & ~push_ok;

  assign rd_data_o = empty ? '0 : mem_q[rd_ptr_q];
  assign count_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (pop_o)   rd_ptr_q <= rd_ptr_q + 1'b1;
      case ({push_ok, pop_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= data_i;
  end
endmodule

// File: rtl/ir_rxq_flags.sv
module ir_rxq_flags #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        flags_o[g] <= 1'b0;
      else if (set_i[g])  flags_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g])  flags_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/ir_rxq_regs.sv
module ir_rxq_regs
  import ir_rxq_pkg::*;
#(
  parameter int CNT_W = 5,
  parameter int DW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       sel_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [31:0]      wdata_i,
  input  logic [NFLAG-1:0] flags_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [DW-1:0]    fifo_data_i,
  output logic [NFLAG-1:0] ien_o,
  output logic [CNT_W-1:0] level_o,
  output logic [NFLAG-1:0] clr_o,
  output logic             pop_req_o,
  output logic [31:0]      rdata_o
);
  logic ien_we, sta_we;
  assign ien_we    = we_i & (sel_i == SEL_IEN);
  assign sta_we    = we_i & (sel_i == SEL_STA);
  assign pop_req_o = re_i & (sel_i == SEL_DAT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) level_o <= '0;
    else if (ien_we) level_o <= wdata_i[FIELD_LO +: CNT_W];
  end

  for (genvar g = 0; g < NFLAG; g++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     ien_o[g] <= 1'b0;
      else if (ien_we) ien_o[g] <= wdata_i[FLAG_POS[g]];
    end
    assign clr_o[g] = sta_we & wdata_i[FLAG_POS[g]];
  end

  always_comb begin
    rdata_o = '0;
    case (sel_i)
      SEL_IEN: begin
        for (int i = 0; i < NFLAG; i++) rdata_o[FLAG_POS[i]] = ien_o[i];
        rdata_o[FIELD_LO +: CNT_W] = level_o;
      end
      SEL_STA: begin
        for (int i = 0; i < NFLAG; i++) rdata_o[FLAG_POS[i]] = flags_i[i];
        rdata_o[FIELD_LO +: CNT_W] = count_i;
      end
      SEL_DAT: rdata_o[DW-1:0] = fifo_data_i;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/ir_rxq.sv
module ir_rxq
  import ir_rxq_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_valid_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          pkt_end_i,
  input  logic [1:0]    reg_sel_i,
  input  logic          reg_we_i,
  input  logic          reg_re_i,
  input  logic [31:0]   wdata_i,
  output logic [31:0]   rdata_o,
  output logic          irq_o
);
  logic [CNT_W-1:0] fifo_count, level;
  logic [DW-1:0]    fifo_rd;
  logic             fifo_full, pop_req, pop, drop;
  logic [NFLAG-1:0] flags, ien, clr, set;

  ir_rxq_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk_i, .rst_ni,
    .push_i    (push_valid_i),
    .data_i    (push_data_i),
    .pop_req_i (pop_req),
    .rd_data_o (fifo_rd),
    .count_o   (fifo_count),
    .full_o    (fifo_full),
    .pop_o     (pop),
    .drop_o    (drop)
  );

  assign set[FLG_OVF]  = drop;
  assign set[FLG_PEND] = pkt_end_i;
  assign set[FLG_AVL]  = (fifo_count > level);

  ir_rxq_flags #(.N(NFLAG)) u_flags (
    .clk_i, .rst_ni,
    .set_i   (set),
    .clr_i   (clr),
    .flags_o (flags)
  );

  ir_rxq_regs #(.CNT_W(CNT_W), .DW(DW)) u_regs (
    .clk_i, .rst_ni,
    .sel_i       (reg_sel_i),
    .we_i        (reg_we_i),
    .re_i        (reg_re_i),
    .wdata_i     (wdata_i),
    .flags_i     (flags),
    .count_i     (fifo_count),
    .fifo_data_i (fifo_rd),
    .ien_o       (ien),
    .level_o     (level),
    .clr_o       (clr),
    .pop_req_o   (pop_req),
    .rdata_o     (rdata_o)
  );

  assign irq_o = |(flags & ien);
endmodule

// File: rtl/ir_rxq_chk.sv
module ir_rxq_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             push_valid_i,
  input logic             pkt_end_i,
  input logic             reg_we_i,
  input logic [1:0]       reg_sel_i,
  input logic [31:0]      wdata_i,
  input logic             irq_o,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] level,
  input logic             full,
  input logic             pop,
  input logic [2:0]       flags,
  input logic [2:0]       ien
);
  a_r4_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count <= CNT_W'(DEPTH));

  a_r3_drop_sets_ovf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && full && !pop) |=> flags[0]);

  a_r3_drop_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_valid_i && full && !pop) |=> (count == CNT_W'(DEPTH)));

  a_r6_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_end_i |=> flags[1]);

  a_r7_pend_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i == 2'd1 && wdata_i[1] && !pkt_end_i) |=> !flags[1]);

  a_r5_avail_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count > level) |=> flags[2]);

  a_r8_no_flag_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flags == 3'b000 || ien == 3'b000) |-> !irq_o);

  a_r9_empty_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (count == '0 && !push_valid_i) |=> (count == '0));
endmodule

bind ir_rxq ir_rxq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .push_valid_i (push_valid_i),
  .pkt_end_i    (pkt_end_i),
  .reg_we_i     (reg_we_i),
  .reg_sel_i    (reg_sel_i),
  .wdata_i      (wdata_i),
  .irq_o        (irq_o),
  .count        (fifo_count),
  .level        (level),
  .full         (fifo_full),
  .pop          (pop),
  .flags        (flags),
  .ien          (ien)
);

// File: tb/ir_rxq_tb.sv
module ir_rxq_tb;
  localparam int DEPTH = 16;
  localparam logic [1:0] S_IEN = 2'd0, S_STA = 2'd1, S_DAT = 2'd2;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        push_valid = 1'b0, pkt_end = 1'b0;
  logic [7:0]  push_data = '0;
  logic [1:0]  sel = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  ir_rxq #(.DEPTH(DEPTH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .push_valid_i(push_valid), .push_data_i(push_data),
    .pkt_end_i(pkt_end), .reg_sel_i(sel), .reg_we_i(we), .reg_re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); push_valid = 1'b1; push_data = b;
    @(negedge clk); push_valid = 1'b0;
  endtask

  task automatic wr(logic [1:0] s, logic [31:0] v);
    @(negedge clk); sel = s; we = 1'b1; wdata = v;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic [1:0] s, output logic [31:0] v);
    @(negedge clk); sel = s; re = 1'b1;
    #1 v = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  function automatic logic [31:0] cnt_of(logic [31:0] st);
    return (st >> 8) & 32'(2*DEPTH-1);
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    rd(S_STA, v); chk("R1 status", v, 0);
    rd(S_IEN, v); chk("R1 enable", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
  endtask

  task automatic t_order();
    logic [31:0] v;
    push(8'hA5); push(8'h3C); push(8'h7E);
    rd(S_STA, v); chk("R4 count3", cnt_of(v), 3);
    rd(S_IEN, v); chk("R10 enable read", v, 0);
    rd(S_STA, v); chk("R10 count after reads", cnt_of(v), 3);
    rd(S_DAT, v); chk("R2 first", v, 32'hA5);
    rd(S_DAT, v); chk("R2 second", v, 32'h3C);
    rd(S_DAT, v); chk("R2 third", v, 32'h7E);
    rd(S_STA, v); chk("R2 drained", cnt_of(v), 0);
  endtask

  task automatic t_empty();
    logic [31:0] v;
    rd(S_DAT, v); chk("R9 empty data", v, 0);
    rd(S_STA, v); chk("R9 empty count", cnt_of(v), 0);
  endtask

  task automatic t_level();
    logic [31:0] v;
    wr(S_STA, 32'hFF);
    wr(S_IEN, (32'd3 << 8) | 32'h10);
    rd(S_IEN, v); chk("R8 enable readback", v, 32'h0310);
    push(8'h11); push(8'h22); push(8'h33);
    @(negedge clk);
    rd(S_STA, v); chk("R5 equal no avail", v[4], 0);
    chk("R8 irq low", {31'b0, irq}, 0);
    push(8'h44);
    @(negedge clk);
    rd(S_STA, v); chk("R5 avail set", v[4], 1);
    chk("R8 irq avail", {31'b0, irq}, 1);
    wr(S_DAT, 32'hFF);
    rd(S_STA, v); chk("R10 data write ignored", cnt_of(v), 4);
    rd(S_DAT, v); chk("R10 data kept 0", v, 32'h11);
    rd(S_DAT, v); chk("R10 data kept 1", v, 32'h22);
    rd(S_DAT, v); chk("R10 data kept 2", v, 32'h33);
    rd(S_DAT, v); chk("R10 data kept 3", v, 32'h44);
    wr(S_STA, 32'h10);
    @(negedge clk);
    rd(S_STA, v); chk("R7 avail cleared", v[4], 0);
    chk("R8 irq cleared", {31'b0, irq}, 0);
  endtask

  task automatic t_overflow();
    logic [31:0] v;
    wr(S_STA, 32'hFF);
    wr(S_IEN, 32'h01);
    for (int i = 0; i < DEPTH; i++) push(8'(i));
    rd(S_STA, v);
    chk("R4 full count", cnt_of(v), DEPTH);
    chk("R3 no ovf yet", v[0], 0);
    chk("R8 irq no ovf", {31'b0, irq}, 0);
    // push and pop together on a full queue
    @(negedge clk); push_valid = 1'b1; push_data = 8'h80; sel = S_DAT; re = 1'b1;
    #1 v = rdata;
    @(negedge clk); push_valid = 1'b0; re = 1'b0;
    chk("R3 simul pop data", v, 0);
    rd(S_STA, v);
    chk("R3 simul count", cnt_of(v), DEPTH);
    chk("R3 simul no ovf", v[0], 0);
    push(8'hEE);
    rd(S_STA, v);
    chk("R3 drop count", cnt_of(v), DEPTH);
    chk("R3 ovf set", v[0], 1);
    chk("R8 irq ovf", {31'b0, irq}, 1);
    for (int i = 1; i < DEPTH; i++) begin
      rd(S_DAT, v); chk("R3 content kept", v, 32'(i));
    end
    rd(S_DAT, v); chk("R3 simul byte last", v, 32'h80);
    wr(S_STA, 32'h01);
    rd(S_STA, v); chk("R7 ovf cleared", v[0], 0);
    chk("R8 irq after ovf clear", {31'b0, irq}, 0);
  endtask

  task automatic t_pkt_end();
    logic [31:0] v;
    wr(S_STA, 32'hFF);
    wr(S_IEN, 32'h00);
    @(negedge clk); pkt_end = 1'b1;
    @(negedge clk); pkt_end = 1'b0;
    rd(S_STA, v); chk("R6 pend set", v[1], 1);
    chk("R8 masked irq", {31'b0, irq}, 0);
    wr(S_IEN, 32'h02);
    chk("R8 irq pend", {31'b0, irq}, 1);
    wr(S_STA, 32'h11);
    rd(S_STA, v); chk("R7 zero bit keeps", v[1], 1);
    wr(S_STA, 32'h02);
    rd(S_STA, v); chk("R7 pend cleared", v[1], 0);
    @(negedge clk); pkt_end = 1'b1; sel = S_STA; we = 1'b1; wdata = 32'h02;
    @(negedge clk); pkt_end = 1'b0; we = 1'b0; wdata = '0;
    rd(S_STA, v); chk("R7 set wins", v[1], 1);
    chk("R8 irq after collision", {31'b0, irq}, 1);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_order();
    t_empty();
    t_level();
    t_overflow();
    t_pkt_end();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule